// File: doc/BRIEF.md
# Packed Decimal Operand Checker

This block walks a decimal operand one byte per accepted transfer, most significant byte first. It has two modes. In check mode it treats the operand as packed decimal, with two digit nibbles per byte and a sign in the final nibble. It traps any nibble that does not fit its position and reports the sign. In pack mode it converts a zoned operand, with one digit per byte, into packed bytes. It streams those bytes out and checks nothing.

A pulse on `start` while idle captures the mode and the length field. The length field holds the byte count minus one, so an operand is 1 to 16 bytes long. Bytes then arrive over a valid/ready handshake. The block has no backpressure on its output stream, and it signals completion with a one-cycle `done` pulse.

Top module: `pdec_unit`

## Requirements
- R1: After an accepted start, `in_ready` stays high until exactly `len_m1`+1 bytes have been accepted. `done` is high for exactly one cycle, in the cycle after the last byte is accepted, and `in_ready` is low in that cycle.
- R2: In check mode (`mode`=0), a byte's high nibble is always a digit. Its low nibble is a digit in every byte except the last. A digit nibble with a value of 10 to 15 sets `dexc`.
- R3: In check mode, the low nibble of the last byte is the sign. A sign nibble with a value of 0 to 9 sets `dexc`.
- R4: `sign_code` holds the sign nibble of the last completed operand. In check mode this is the low nibble of the last byte; in pack mode it is the high nibble of the last byte. `sign_neg` is 1 for codes 0xB and 0xD and 0 for every other code. Codes 0xA, 0xC, 0xE and 0xF count as positive.
- R5: Once set, `dexc` stays set until the next accepted start, and that start clears it.
- R6: In pack mode (`mode`=1), the block emits floor(N/2)+1 packed bytes for N zoned bytes. Each packed byte appears on `out_byte` with `out_valid` high for one cycle, in the cycle after the byte that completes it is accepted. The packed digits are the low nibbles of the zoned bytes, in order. The last packed byte holds the last digit in its high nibble and the last byte's zone nibble, unchanged, in its low nibble.
- R7: Pack mode never sets `dexc`, whatever the nibble values.
- R8: A `start` pulse while an operand is in progress is ignored: the mode, the length and the output stream of the running operand are unchanged.
- R9: After reset, `in_ready`, `done`, `dexc`, `out_valid`, `sign_code` and `sign_neg` are all 0.
- R10: In pack mode with an even N, the first packed byte carries a zero high nibble ahead of the first digit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operand (taken only while idle) |
| mode | input | 1 | 0 = check packed operand, 1 = pack zoned operand |
| len_m1 | input | 4 | Operand byte count minus one |
| in_valid | input | 1 | Input byte is valid |
| in_byte | input | 8 | Operand byte, most significant first |
| in_ready | output | 1 | Block accepts a byte |
| out_valid | output | 1 | Packed output byte is valid |
| out_byte | output | 8 | Packed output byte |
| sign_code | output | 4 | Sign nibble of the last operand |
| sign_neg | output | 1 | Sign code denotes a negative value |
| done | output | 1 | One-cycle completion pulse |
| dexc | output | 1 | Sticky data-exception flag |

## Verification
Several properties are checked on every cycle: `done` is a single pulse that follows an accepted byte, `dexc` stays sticky and is cleared by an accepted start, pack mode never raises `dexc`, and a numeric sign code in check mode is always flagged when the operand completes. Other behaviour can only be shown by the bench's scenarios, each compared against independently computed expectations: the exact byte count per operand, the packed byte values including the zero pad for even lengths, the digit checks at each nibble position, the sign classification, and the fact that a start arriving mid-operand is ignored.

// File: rtl/pdec_unit.sv
module pdec_unit #(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mode,
  input  logic [LEN_W-1:0] len_m1,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  output logic             in_ready,
  output logic             out_valid,
  output logic [7:0]       out_byte,
  output logic [3:0]       sign_code,
  output logic             sign_neg,
  output logic             done,
  output logic             dexc
);
  logic             busy, mode_q, have_hi;
  logic [LEN_W-1:0] cnt;
  logic [3:0]       hi_nib;

  wire fire    = in_valid & busy;
  wire last    = (cnt == '0);
  wire hi_bad  = in_byte[7:4] > 4'd9;
  wire lo_bad  = last ? (in_byte[3:0] <= 4'd9) : (in_byte[3:0] > 4'd9);
  wire chk_bad = hi_bad | lo_bad;

  assign in_ready = busy;
  assign sign_neg = (sign_code == 4'hB) | (sign_code == 4'hD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      mode_q    <= 1'b0;
      have_hi   <= 1'b0;
      cnt       <= '0;
      hi_nib    <= 4'h0;
      out_valid <= 1'b0;
      out_byte  <= 8'h00;
      sign_code <= 4'h0;
      done      <= 1'b0;
      dexc      <= 1'b0;
    end else begin
      done      <= 1'b0;
      out_valid <= 1'b0;
      if (start && !busy) begin
        busy    <= 1'b1;
        mode_q  <= mode;
        cnt     <= len_m1;
        have_hi <= mode & len_m1[0];
        hi_nib  <= 4'h0;
        dexc    <= 1'b0;
      end else if (fire) begin
        cnt <= cnt - 1'b1;
        if (last) begin
          busy      <= 1'b0;
          done      <= 1'b1;
          sign_code <= mode_q ? in_byte[7:4] : in_byte[3:0];
        end
        if (!mode_q) begin
          if (chk_bad) dexc <= 1'b1;
        end else if (last) begin
          out_byte  <= {in_byte[3:0], in_byte[7:4]};
          out_valid <= 1'b1;
        end else if (have_hi) begin
          out_byte  <= {hi_nib, in_byte[3:0]};
          out_valid <= 1'b1;
          have_hi   <= 1'b0;
        end else begin
          hi_nib  <= in_byte[3:0];
          have_hi <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pdec_unit_sva.sv
module pdec_unit_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       in_valid,
  input logic       in_ready,
  input logic       done,
  input logic       dexc,
  input logic       out_valid,
  input logic       mode_q,
  input logic [3:0] sign_code
);
  p_done_follows_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(in_valid && in_ready) && !in_ready));

  p_done_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_sign_trap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !mode_q && sign_code <= 4'd9) |-> dexc);

  p_dexc_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dexc && !(start && !in_ready)) |=> dexc);

  p_start_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !in_ready) |=> !dexc);

  p_out_follows_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid && in_ready));

  p_pack_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && mode_q) |=> !dexc);
endmodule

bind pdec_unit pdec_unit_sva u_sva (
  .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
  .in_ready(in_ready), .done(done), .dexc(dexc), .out_valid(out_valid),
  .mode_q(mode_q), .sign_code(sign_code)
);

// File: tb/pdec_unit_tb.sv
module pdec_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, mode = 1'b0, in_valid = 1'b0;
  logic [3:0] len_m1 = 4'd0;
  logic [7:0] in_byte = 8'h00;
  logic       in_ready, out_valid, sign_neg, done, dexc;
  logic [7:0] out_byte;
  logic [3:0] sign_code;

  int checks = 0, errors = 0, finished = 0;
  logic [7:0] ops [16];
  logic [7:0] obs [32];
  logic [7:0] exp_out [32];
  int obs_n = 0, done_n = 0, exp_n = 0;

  always #10 clk = ~clk;

  pdec_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .len_m1(len_m1),
    .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
    .out_valid(out_valid), .out_byte(out_byte), .sign_code(sign_code),
    .sign_neg(sign_neg), .done(done), .dexc(dexc)
  );

  always @(negedge clk) begin
    if (out_valid && obs_n < 32) begin obs[obs_n] = out_byte; obs_n++; end
    if (done) done_n++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic bit exp_bad(input int n);
    bit bad = 0;
    for (int i = 0; i < n; i++) begin
      if (ops[i][7:4] > 9) bad = 1;
      if (i == n - 1) begin if (ops[i][3:0] < 10) bad = 1; end
      else if (ops[i][3:0] > 9) bad = 1;
    end
    return bad;
  endfunction

  task automatic calc_pack(input int n);
    logic [3:0] nibs [34];
    int k = 0;
    if (n % 2 == 0) begin nibs[k] = 4'h0; k++; end
    for (int i = 0; i < n; i++) begin nibs[k] = ops[i][3:0]; k++; end
    nibs[k] = ops[n-1][7:4]; k++;
    exp_n = k / 2;
    for (int j = 0; j < exp_n; j++) exp_out[j] = {nibs[2*j], nibs[2*j+1]};
  endtask

  task automatic run_op(input bit m, input int n, input bit inject);
    logic [3:0] sc;
    obs_n = 0; done_n = 0;
    @(negedge clk);
    start = 1; mode = m; len_m1 = 4'(n - 1);
    @(negedge clk);
    start = 0;
    chk(dexc == 0, "R5 start clears", dexc, 0);
    for (int i = 0; i < n; i++) begin
      if ($urandom_range(3) == 0) repeat ($urandom_range(2) + 1) @(negedge clk);
      chk(in_ready == 1, "R1 ready held", in_ready, 1);
      if (inject && i == 1) begin start = 1; mode = ~m; len_m1 = 4'd0; end
      in_valid = 1; in_byte = ops[i];
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 0; start = 0;
      if (i < n - 1) chk(done == 0, "R1 no early done", done, 0);
    end
    chk(done == 1 && in_ready == 0, "R1 done pulse", {done, in_ready}, 2);
    sc = m ? ops[n-1][7:4] : ops[n-1][3:0];
    chk(sign_code == sc, "R4 sign code", sign_code, sc);
    chk(sign_neg == (sc == 4'hB || sc == 4'hD), "R4 sign class", sign_neg, (sc == 4'hB || sc == 4'hD));
    if (m) chk(dexc == 0, "R7 pack no check", dexc, 0);
    else chk(dexc == exp_bad(n), "R2 R3 data exception", dexc, exp_bad(n));
    @(negedge clk);
    chk(done == 0 && done_n == 1, "R1 single done", done_n, 1);
    if (inject) chk(in_ready == 0, "R8 mid start ignored", in_ready, 0);
    if (m) begin
      calc_pack(n);
      chk(obs_n == exp_n, "R6 packed count", obs_n, exp_n);
      for (int j = 0; j < exp_n && j < obs_n; j++)
        chk(obs[j] == exp_out[j], (n % 2 == 0 && j == 0) ? "R10 pad byte" : "R6 packed byte", obs[j], exp_out[j]);
    end else chk(obs_n == 0, "R6 no output in check mode", obs_n, 0);
  endtask

  task automatic fill_check(input int n);
    for (int i = 0; i < n; i++) ops[i] = {4'($urandom_range(9)), 4'($urandom_range(9))};
    ops[n-1][3:0] = 4'($urandom_range(15, 10));
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(in_ready == 0 && done == 0 && dexc == 0 && out_valid == 0 && sign_code == 0 && sign_neg == 0,
        "R9 reset state", {in_ready, done, dexc, out_valid, sign_code}, 0);
    rst_n = 1;
    @(negedge clk);

    ops[0] = 8'h7C; run_op(0, 1, 0);
    ops[0] = 8'h35; run_op(0, 1, 0);
    fill_check(3); ops[1][7:4] = 4'hA; run_op(0, 3, 0);
    fill_check(4); ops[2][3:0] = 4'hF; run_op(0, 4, 0);
    fill_check(2); ops[1][3:0] = 4'hD; run_op(0, 2, 0);
    repeat (4) @(negedge clk);
    ops[0] = 8'h1B; ops[1] = 8'hE4; run_op(0, 2, 0);
    repeat (5) @(negedge clk);
    chk(dexc == 1, "R5 sticky while idle", dexc, 1);
    for (int i = 0; i < 2; i++) ops[i] = 8'hF0 + 8'(i + 1);
    ops[1][7:4] = 4'hD; run_op(1, 2, 0);
    for (int i = 0; i < 3; i++) ops[i] = 8'($urandom);
    run_op(1, 3, 0);
    for (int i = 0; i < 16; i++) ops[i] = {4'hF, 4'(i % 10)};
    run_op(1, 16, 0);
    fill_check(16); run_op(0, 16, 0);
    for (int i = 0; i < 5; i++) ops[i] = 8'($urandom);
    run_op(1, 5, 1);
    fill_check(6); run_op(0, 6, 1);

    for (int t = 0; t < 60; t++) begin
      int n = $urandom_range(16, 1);
      bit m = 1'($urandom_range(1));
      if (m) for (int i = 0; i < n; i++) ops[i] = 8'($urandom);
      else begin
        fill_check(n);
        if ($urandom_range(3) == 0) ops[$urandom_range(n - 1)] = 8'($urandom);
      end
      run_op(m, n, 0);
    end
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule